// File: doc/BRIEF.md
# Predicated 8-bit ALU with Flags

This block is the arithmetic and logic stage of a small 8-bit core. Each cycle it takes a 3-bit operation code, a destination operand and a source operand. The source operand has already been chosen upstream and may be a register value, an 8-bit immediate or a sign-extended short immediate. It also takes an execute-enable from the condition unit. The block returns the result and a write-enable for the register file. It also keeps a registered set of Carry, Zero and Sign flags.

The design uses one shared adder. Subtraction is formed by inverting the destination operand and forcing a carry-in of one. The inversion depends only on the opcode bits, and the same inverted operand feeds the and-not operation in the boolean group. The two compare operations are subtractions whose result is never written. The signed compare flips the top bit of both adder inputs, so Carry gives the signed ordering. When execute-enable is low, nothing is committed: the write-enable stays low and the flags hold.

The result and write-enable are combinational and follow the inputs in the same cycle. The flags change only at a rising clock edge. There is no stream traffic at this block's edge, so every pin is a plain control or data signal and none of them applies back-pressure.

Top module: `pred_alu8`

## Requirements
- R1: Opcode 0 gives SND|SRI, opcode 1 gives SND^SRI and opcode 2 gives SND&SRI on `result`.
- R2: Opcode 3 gives (~SND)&SRI on `result`.
- R3: Opcode 7 gives (SND+SRI) mod 256 on `result`. When it executes, Carry is set to the carry out of bit 7.
- R4: Opcode 6 gives (SRI−SND) mod 256 on `result`. When it executes, Carry becomes 1 exactly when SRI ≥ SND as unsigned numbers.
- R5: Opcode 4 (unsigned compare) sets Carry the same way as opcode 6 and never raises `wr_en`.
- R6: Opcode 5 (signed compare) puts (SRI−SND) mod 256 on `result` and never raises `wr_en`. When it executes, Carry becomes 1 exactly when SRI ≥ SND as two's-complement numbers.
- R7: An executed opcode 0 to 3 leaves Carry unchanged.
- R8: After an executed operation of any opcode, Zero is 1 exactly when all 8 result bits were 0, and Sign equals result bit 7. Both update at the next rising edge.
- R9: While `exec_en` is low, `wr_en` is low and Carry, Zero and Sign keep their values through the clock edge.
- R10: A rising edge with `rst` high clears Carry, Zero and Sign to 0.
- R11: For opcodes 0 to 3, 6 and 7, `wr_en` equals `exec_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op | input | 3 | Operation code (low three bits of the main opcode) |
| snd | input | 8 | Destination operand |
| sri | input | 8 | Source operand (register, Imm8 or extended Imm4) |
| exec_en | input | 1 | Predicate result; high commits the operation |
| result | output | 8 | Combinational result of the operation |
| wr_en | output | 1 | Write-back enable for the destination register |
| flag_c | output | 1 | Registered Carry flag |
| flag_z | output | 1 | Registered Zero flag |
| flag_s | output | 1 | Registered Sign flag |

## Verification
`result` and `wr_en` are due in the same cycle the inputs are applied. The bench drives the inputs at the falling edge and compares them one nanosecond later. The flags are due after the next rising edge. The bench model therefore updates its flags only once the comparison for a step is done, and the next step compares the design's flags against them. This puts every flag value exactly one edge behind the operation that produced it. Directed corner operands and a long random run both go through this same per-cycle comparison.

// File: rtl/pred_alu8_pkg.sv
package pred_alu8_pkg;
  typedef enum logic [2:0] {
    OP_OR   = 3'd0,
    OP_XOR  = 3'd1,
    OP_AND  = 3'd2,
    OP_ANDN = 3'd3,
    OP_CMPU = 3'd4,
    OP_CMPS = 3'd5,
    OP_SUB  = 3'd6,
    OP_ADD  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu8_bitlogic.sv
module alu8_bitlogic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  // sel: 0 OR, 1 XOR, 2/3 AND (operand a arrives pre-inverted for and-not)
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        2'd0:    y[i] = a[i] | b[i];
        2'd1:    y[i] = a[i] ^ b[i];
        default: y[i] = a[i] & b[i];
      endcase
    end
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         signed_order,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int MSB = W - 1;
  logic [W-1:0] a_adj, b_adj;

  always_comb begin
    a_adj = a;
    b_adj = b;
    // Flipping both MSBs leaves the sum bits unchanged; only carry-out moves.
    if (signed_order) begin
      a_adj[MSB] = ~a[MSB];
      b_adj[MSB] = ~b[MSB];
    end
    {cout, sum} = {1'b0, a_adj} + {1'b0, b_adj} + {{W{1'b0}}, cin};
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic upd_c,
  input  logic c_next,
  input  logic z_next,
  input  logic s_next,
  output logic c_q,
  output logic z_q,
  output logic s_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
      s_q <= 1'b0;
    end else if (en) begin
      z_q <= z_next;
      s_q <= s_next;
      if (upd_c) c_q <= c_next;
    end
  end

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(c_q) && $stable(z_q) && $stable(s_q)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!c_q && !z_q && !s_q));
endmodule

// File: rtl/pred_alu8.sv
module pred_alu8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op,
  input  logic [W-1:0] snd,
  input  logic [W-1:0] sri,
  input  logic         exec_en,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         flag_c,
  output logic flag_z,
  output logic flag_s
);
  import pred_alu8_pkg::*;

  localparam int MSB = W - 1;

  alu_op_e      opc;
  logic         inv_snd;
  logic         is_arith;
  logic         is_cmp;
  logic [W-1:0] a_op;
  logic [W-1:0] logic_y;
  logic [W-1:0] sum_y;
  logic         carry_out;

  assign opc      = alu_op_e'(op);
  // Inverting term: high for and-not, both compares and subtract; low for add.
  assign inv_snd  = op[2] ^ (op[1] & op[0]);
  assign is_arith = op[2];
  assign is_cmp   = (opc == OP_CMPU) || (opc == OP_CMPS);
  assign a_op     = snd ^ {W{inv_snd}};

  alu8_bitlogic #(.W(W)) u_logic (
    .a   (a_op),
    .b   (sri),
    .sel (op[1:0]),
    .y   (logic_y)
  );

  alu8_adder #(.W(W)) u_adder (
    .a            (a_op),
    .b            (sri),
    .cin          (inv_snd),
    .signed_order (opc == OP_CMPS),
    .sum          (sum_y),
    .cout         (carry_out)
  );

  assign result = is_arith ? sum_y : logic_y;
  assign wr_en  = exec_en & ~is_cmp;

  alu8_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .en     (exec_en),
    .upd_c  (is_arith),
    .c_next (carry_out),
    .z_next (result == '0),
    .s_next (result[MSB]),
    .c_q    (flag_c),
    .z_q    (flag_z),
    .s_q    (flag_s)
  );

  assert_write_needs_exec_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> exec_en);

  assert_logic_keeps_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !op[2]) |=> $stable(flag_c));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (flag_z == ($past(result) == '0)));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (flag_s == $past(result[MSB])));

  assert_signed_order_R6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == 3'd5) |=> (flag_c == ($signed($past(sri)) >= $signed($past(snd)))));

  assert_unsigned_order_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == 3'd4) |=> (flag_c == ($past(sri) >= $past(snd))));
endmodule

// File: tb/pred_alu8_tb.sv
module pred_alu8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = '0;
  logic [7:0] snd = '0, sri = '0;
  logic       exec_en = 1'b0;
  logic [7:0] result;
  logic       wr_en, flag_c, flag_z, flag_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_c = 0, m_z = 0, m_s = 0;

  always #2.5 clk = ~clk;

  pred_alu8 u_dut (
    .clk(clk), .rst(rst), .op(op), .snd(snd), .sri(sri), .exec_en(exec_en),
    .result(result), .wr_en(wr_en), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string op_req(input int o);
    case (o)
      0, 1, 2: return "R1";
      3:       return "R2";
      4:       return "R5";
      5:       return "R6";
      6:       return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic step(input int o, input int s, input int r, input bit en);
    int  exp_res;
    bit  exp_c;
    @(negedge clk);
    op = 3'(o); snd = 8'(s); sri = 8'(r); exec_en = en;
    #1;
    case (o)
      0: exp_res = s | r;
      1: exp_res = s ^ r;
      2: exp_res = s & r;
      3: exp_res = (~s) & r & 255;
      4, 5, 6: exp_res = (r - s) & 255;
      default: exp_res = (s + r) & 255;
    endcase
    case (o)
      4, 6: exp_c = (r >= s);
      5: exp_c = ($signed(8'(r)) >= $signed(8'(s)));
      7: exp_c = ((s + r) > 255);
      default: exp_c = m_c;
    endcase
    chk(op_req(o), "result", result, exp_res);
    // R5 R6 R9 R11: write enable
    chk((o == 4 || o == 5) ? op_req(o) : (en ? "R11" : "R9"), "wr_en", wr_en,
        (en && o != 4 && o != 5) ? 1 : 0);
    // R7 R8 R9: flags from the previous edges
    chk("R7", "flag_c", flag_c, m_c);
    chk("R8", "flag_z", flag_z, m_z);
    chk("R8", "flag_s", flag_s, m_s);
    if (en) begin
      m_c = exp_c;
      m_z = (exp_res == 0);
      m_s = exp_res[7];
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset cleared flags
    chk("R10", "flag_c", flag_c, 0);
    chk("R10", "flag_z", flag_z, 0);
    chk("R10", "flag_s", flag_s, 0);
    rst = 1'b0;
    step(7, 8'hFF, 8'h01, 1);   // R3 wrap to zero, carry out
    step(0, 8'h00, 8'h00, 1);   // R7 OR leaves carry, R8 zero
    step(3, 8'hF0, 8'hFF, 1);   // R2 and-not
    step(6, 8'h10, 8'h10, 1);   // R4 equal: zero, carry 1
    step(6, 8'h11, 8'h10, 1);   // R4 borrow
    step(4, 8'h05, 8'h80, 1);   // R5 unsigned greater
    step(5, 8'h05, 8'h80, 1);   // R6 signed less
    step(5, 8'h80, 8'h7F, 1);   // R6 signed greater
    step(5, 8'hFF, 8'hFF, 1);   // R6 signed equal
    step(7, 8'h40, 8'h40, 0);   // R9 suppressed
    step(1, 8'hAA, 8'h55, 0);   // R9 suppressed
    step(2, 8'hAA, 8'h0F, 1);   // R1 and
    step(1, 8'hAA, 8'hAA, 1);   // R1 xor zero
    step(0, 8'h00, 8'h00, 0);   // observe flags after the xor
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 3) != 0));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "flag_c", flag_c, 0);
    chk("R10", "flag_z", flag_z, 0);
    chk("R10", "flag_s", flag_s, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule